// File: doc/BRIEF.md
# VLAN Membership Receive Filter

This block sits early in a receive path and decides, one decision per incoming frame header, whether a frame carrying a VLAN tag belongs to a VLAN the host has enabled. It keeps a 4096-bit membership bitmap, one bit per VLAN ID, stored as 128 words of 32 bits. The host reads and writes these words over a simple register bus.

For each header it is given bytes 12 to 15 of the frame. It compares bytes 12–13 against a programmable tag protocol identifier. When filtering is enabled and the frame is tagged, the block takes the 12-bit VLAN ID from bytes 14–15 and looks up the matching bitmap bit. A clear bit drops the frame.

The pass/drop result gates the address filter that follows, which is not part of this block. A frame this block drops therefore stays dropped even when that later filter would accept every frame, as in promiscuous mode.

Top module: `vid_member_filter`

## Requirements
- R1: A header counts as tagged exactly when `hdr_bytes[31:16]` (frame bytes 12–13, big-endian) equals `tag_type`. The identifier is programmable, so changing `tag_type` changes which frames count as tagged.
- R2: When `filt_en` is low at the header strobe, the decision is pass for every frame.
- R3: An untagged frame is always passed, whatever the table holds.
- R4: The VLAN ID is `hdr_bytes[11:0]`, the low 12 bits of frame bytes 14–15. Bits `hdr_bytes[15:12]` (priority and CFI) have no effect on the decision.
- R5: For a tagged frame with filtering enabled, the table word index is VID[11:5] and the bit inside that word is VID[4:0]. A 0 bit gives drop (`dec_pass` low) and a 1 bit gives pass.
- R6: `dec_valid` pulses high exactly two clock edges after the edge that samples `hdr_valid`, once per header. Back-to-back headers give back-to-back decisions. `dec_pass` is low whenever `dec_valid` is low.
- R7: A write (`reg_wr`) stores `reg_wdata` into word `reg_addr` at the clock edge, and each of the 128 words is independent. A read (`reg_rd`) places the word's contents from before that edge on `reg_rdata` after the edge, and `reg_rdata` holds its value until the next read.
- R8: Write-first: a write issued in the cycle after a header strobe (the lookup cycle) to the word that header selects is seen by that header's decision.
- R9: Reset clears every table word to zero, clears `reg_rdata` and holds `dec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Table word write strobe |
| reg_rd | input | 1 | Table word read strobe |
| reg_addr | input | 7 | Table word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, updated one edge after `reg_rd` |
| filt_en | input | 1 | Enables VLAN membership filtering |
| tag_type | input | 16 | Tag protocol identifier to match against bytes 12–13 |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| hdr_bytes | input | 32 | Frame bytes 12..15, byte 12 in bits 31:24 |
| dec_valid | output | 1 | Decision strobe |
| dec_pass | output | 1 | 1 = forward to address filtering, 0 = drop |

## Verification
The bench builds the block with its default parameters: a 12-bit VLAN ID and 32-bit words, giving the full 128-word table. With these values the extreme IDs 0 and 4095 and the word edges at IDs 31/32 are all reachable. It also writes and reads back every word, so each word's independence is exercised. Directed scenarios cover the priority bits, a reprogrammed tag identifier, back-to-back headers and a table write that lands in the lookup cycle.

// File: rtl/vidf_pkg.sv
package vidf_pkg;
  // Fixed by the frame format: tag identifier and tag control field widths
  localparam int TPID_W = 16;
  localparam int TCI_W  = 16;

  // Split a VLAN ID into table word index and bit position
  function automatic int unsigned vid_word(input int unsigned vid, input int unsigned bit_w);
    return vid >> bit_w;
  endfunction

  function automatic int unsigned vid_bit(input int unsigned vid, input int unsigned bit_w);
    return vid & ((32'd1 << bit_w) - 32'd1);
  endfunction
endpackage

// File: rtl/vidf_parse.sv
module vidf_parse
  import vidf_pkg::*;
#(
  parameter int VID_W  = 12,
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int IDX_W = VID_W - BIT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hdr_valid,
  input  logic [TPID_W+TCI_W-1:0] hdr_bytes,
  input  logic                    filt_en,
  input  logic [TPID_W-1:0]       tag_type,
  output logic                    s1_valid,
  output logic                    s1_tagged,
  output logic                    s1_en,
  output logic [IDX_W-1:0]        s1_idx,
  output logic [BIT_W-1:0]        s1_bit
);
  logic [TPID_W-1:0] tpid_field;
  logic [VID_W-1:0]  vid_field;
  logic              unused_prio;

  assign tpid_field  = hdr_bytes[TPID_W+TCI_W-1:TCI_W];
  assign vid_field   = hdr_bytes[VID_W-1:0];
  assign unused_prio = ^hdr_bytes[TCI_W-1:VID_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_tagged <= 1'b0;
      s1_en     <= 1'b0;
      s1_idx    <= '0;
      s1_bit    <= '0;
    end else begin
      s1_valid <= hdr_valid;
      if (hdr_valid) begin
        s1_tagged <= (tpid_field == tag_type);
        s1_en     <= filt_en;
        s1_idx    <= IDX_W'(vid_word(32'(vid_field), BIT_W));
        s1_bit    <= BIT_W'(vid_bit(32'(vid_field), BIT_W));
      end
    end
  end

  // R6: every header strobe enters the lookup stage on the next edge
  p_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> s1_valid);
endmodule

// File: rtl/vidf_table.sv
module vidf_table #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 7,
  localparam int NWORDS = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [WORD_W-1:0] lk_word
);
  logic [WORD_W-1:0] tbl [NWORDS];
  logic [WORD_W-1:0] addr_word;
  logic              lk_collide;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[w] <= '0;
      else if (reg_wr && reg_addr == IDX_W'(w))
        tbl[w] <= reg_wdata;
    end
  end

  assign addr_word  = tbl[reg_addr];
  assign lk_collide = reg_wr && (reg_addr == lk_idx);
  // Write-first: a same-cycle write to the looked-up word bypasses the store
  assign lk_word    = lk_collide ? reg_wdata : tbl[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= addr_word;
  end

  // R7: a write lands in the addressed word
  p_wr_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> tbl[$past(reg_addr)] == $past(reg_wdata));
  // R7: read data is the addressed word as it stood before the edge
  p_rd_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rdata == $past(addr_word));
  // R7: read data holds between reads
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/vid_member_filter.sv
module vid_member_filter
  import vidf_pkg::*;
#(
  parameter int VID_W  = 12,
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int IDX_W = VID_W - BIT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [IDX_W-1:0]        reg_addr,
  input  logic [WORD_W-1:0]       reg_wdata,
  output logic [WORD_W-1:0]       reg_rdata,
  input  logic                    filt_en,
  input  logic [TPID_W-1:0]       tag_type,
  input  logic                    hdr_valid,
  input  logic [TPID_W+TCI_W-1:0] hdr_bytes,
  output logic                    dec_valid,
  output logic                    dec_pass
);
  logic              s1_valid, s1_tagged, s1_en;
  logic [IDX_W-1:0]  s1_idx;
  logic [BIT_W-1:0]  s1_bit;
  logic [WORD_W-1:0] lk_word;
  logic              member_hit;
  logic              must_check;

  vidf_parse #(.VID_W(VID_W), .WORD_W(WORD_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_bytes(hdr_bytes),
    .filt_en(filt_en), .tag_type(tag_type), .s1_valid(s1_valid),
    .s1_tagged(s1_tagged), .s1_en(s1_en), .s1_idx(s1_idx), .s1_bit(s1_bit)
  );

  vidf_table #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_idx(s1_idx), .lk_word(lk_word)
  );

  assign member_hit = lk_word[s1_bit];
  assign must_check = s1_en && s1_tagged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_pass  <= 1'b0;
    end else begin
      dec_valid <= s1_valid;
      dec_pass  <= s1_valid && (!must_check || member_hit);
    end
  end

  // R6: decision two edges after the header strobe
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> ##2 dec_valid);
  // R6: no pass without a decision strobe
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_pass);
  // R2: filtering disabled always passes
  p_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_en) |=> dec_pass);
  // R3: untagged always passes
  p_untag_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_tagged) |=> dec_pass);
  // R5: a drop only follows a tagged, filtered lookup of a clear bit
  p_drop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_pass) |-> ($past(must_check) && !$past(member_hit)));
  // R8: a colliding write is what the lookup sees
  p_write_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && reg_wr && reg_addr == s1_idx) |-> lk_word == reg_wdata);
endmodule

// File: tb/vid_member_filter_test.sv
module vid_member_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        filt_en = 1'b0;
  logic [15:0] tag_type = 16'h8100;
  logic        hdr_valid = 1'b0;
  logic [31:0] hdr_bytes = '0;
  logic        dec_valid, dec_pass;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [128];
  bit pass_q [$];

  always #10 clk = ~clk;

  vid_member_filter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .filt_en(filt_en), .tag_type(tag_type), .hdr_valid(hdr_valid),
    .hdr_bytes(hdr_bytes), .dec_valid(dec_valid), .dec_pass(dec_pass)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Bench-side rule: pass unless filtering, tagged and member bit clear
  function automatic bit model_pass(input logic [31:0] h, input bit en, input logic [15:0] tt);
    int unsigned vid;
    vid = h & 32'hFFF;
    if (!en || h[31:16] != tt) return 1'b1;
    return shadow[vid / 32][vid % 32];
  endfunction

  task automatic wr_word(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    shadow[idx] = d;
  endtask

  task automatic rd_word(input int idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 7'(idx);
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, $sformatf("read word %0d", idx), reg_rdata, exp);
  endtask

  task automatic frame(input logic [31:0] h, input bit en, input string req);
    bit exp;
    exp = model_pass(h, en, tag_type);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_bytes = h; filt_en = en;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R6", "no early decision", 32'(dec_valid), 32'd0);
    @(negedge clk);
    chk("R6", "decision strobe", 32'(dec_valid), 32'd1);
    chk(req, $sformatf("pass for hdr %h", h), 32'(dec_pass), 32'(exp));
    @(negedge clk);
    chk("R6", "single strobe", 32'(dec_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R9", "dec_valid after reset", 32'(dec_valid), 32'd0);
    chk("R9", "rdata after reset", reg_rdata, 32'd0);
    rd_word(0, 32'd0, "R9");
    rd_word(127, 32'd0, "R9");
  endtask

  task automatic t_registers;
    for (int i = 0; i < 128; i++) wr_word(i, 32'hA5000000 ^ (32'(i) * 32'h01010101));
    for (int i = 0; i < 128; i++) rd_word(i, 32'hA5000000 ^ (32'(i) * 32'h01010101), "R7");
    for (int i = 0; i < 128; i++) wr_word(i, 32'd0);
  endtask

  task automatic t_membership;
    wr_word(0, 32'h0000_0001);   // VID 0
    wr_word(1, 32'h0000_0001);   // VID 32
    wr_word(127, 32'h8000_0000); // VID 4095
    frame(32'h8100_0000, 1'b1, "R5");
    frame(32'h8100_0001, 1'b1, "R5");
    frame(32'h8100_001F, 1'b1, "R5");
    frame(32'h8100_0020, 1'b1, "R5");
    frame(32'h8100_0FFF, 1'b1, "R5");
    frame(32'h8100_0FFE, 1'b1, "R5");
    frame(32'h8100_0040, 1'b1, "R5");
  endtask

  task automatic t_disabled;
    frame(32'h8100_0005, 1'b0, "R2");
    frame(32'h8100_0FFE, 1'b0, "R2");
  endtask

  task automatic t_untagged;
    frame(32'h0800_0005, 1'b1, "R3");
    frame(32'h86DD_0FFE, 1'b1, "R3");
  endtask

  task automatic t_prio_bits;
    frame(32'h8100_F000, 1'b1, "R4");
    frame(32'h8100_E020, 1'b1, "R4");
    frame(32'h8100_7005, 1'b1, "R4");
  endtask

  task automatic t_tag_type;
    tag_type = 16'h88A8;
    frame(32'h8100_0005, 1'b1, "R1");
    frame(32'h88A8_0005, 1'b1, "R1");
    frame(32'h88A8_0000, 1'b1, "R1");
    tag_type = 16'h8100;
    frame(32'h8100_0005, 1'b1, "R1");
  endtask

  task automatic t_write_first;
    @(negedge clk);
    hdr_valid = 1'b1; hdr_bytes = 32'h8100_0123; filt_en = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = 7'd9; reg_wdata = 32'h0000_0008;
    @(negedge clk);
    reg_wr = 1'b0;
    shadow[9] = 32'h0000_0008;
    chk("R8", "decision strobe", 32'(dec_valid), 32'd1);
    chk("R8", "write-first pass", 32'(dec_pass), 32'd1);
    rd_word(9, 32'h0000_0008, "R8");
  endtask

  task automatic t_back_to_back;
    logic [31:0] hs [5];
    hs[0] = 32'h8100_0000; hs[1] = 32'h8100_0002; hs[2] = 32'h0800_0002;
    hs[3] = 32'h8100_0FFF; hs[4] = 32'h8100_0021;
    pass_q.delete();
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R6", "back-to-back strobe", 32'(dec_valid), 32'd1);
        chk("R6", "back-to-back pass", 32'(dec_pass), 32'(pass_q.pop_front()));
      end
      if (i < 5) begin
        hdr_valid = 1'b1; hdr_bytes = hs[i]; filt_en = 1'b1;
        pass_q.push_back(model_pass(hs[i], 1'b1, tag_type));
      end else begin
        hdr_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R6", "strobe ends", 32'(dec_valid), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_registers();
    t_membership();
    t_disabled();
    t_untagged();
    t_prio_bits();
    t_tag_type();
    t_write_first();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule